// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block follows a list of scatter-gather descriptors held in memory and turns each one into a segment record for a downstream data mover. A walk starts with a one-cycle `start` pulse that carries the list's base address. Each descriptor occupies 8 bytes. The length word sits at the lower offset and the address word at the higher one. Both are 32-bit values as delivered by the read port. The block fetches them through a simple port that has a request handshake and carries one read at a time.

Each segment holds a masked address, a masked length and a final flag, and leaves through a valid/ready handshake. The walk ends after the descriptor that carries the end marker. A list with no end marker is cut off at a fixed entry budget and reported as an error. Either way the block raises a one-cycle completion pulse with the error status and the number of descriptors consumed.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset `busy`, `memReqValid`, `segValid`, `done` and `doneErr` are 0, and `doneCount` is 0.
- R2: For descriptor i, the block first requests the length word at base + 8*i, then the address word at base + 8*i + 4. Only one read is ever in flight. A request holds its address until it is accepted.
- R3: `segLen` equals bits [27:0] of the length word, and `segLast` equals bit 31 of that word. Bits [30:28] have no effect.
- R4: `segAddr` equals bits [30:0] of the address word. Bit 31 has no effect.
- R5: A segment is offered only after both words of its descriptor have returned, with no read outstanding. Its fields stay stable while `segValid` is high and `segReady` is low.
- R6: The segment with the end marker (bit 31 of the length word) is the last one emitted. One cycle after its handshake, `done` pulses with `doneErr`=0 and `doneCount` equal to the number of segments emitted.
- R7: If MAX_ENTRIES segments are emitted and none has the end marker, the walk stops. `done` pulses with `doneErr`=1 and `doneCount`=MAX_ENTRIES. If the end marker arrives on entry MAX_ENTRIES itself, `doneErr` is 0.
- R8: A `start` pulse while `busy` is high is ignored. The running walk keeps its base address and its segment sequence.
- R9: `done` lasts exactly one cycle, and `busy` is low in that cycle. `doneErr` and `doneCount` hold their values until the next walk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| baseAddr | input | ADDR_W | Address of descriptor 0, sampled with start |
| busy | output | 1 | A walk is in progress |
| memReqValid | output | 1 | Read request pending |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Byte address of the requested word |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data word |
| segValid | output | 1 | Segment record valid |
| segReady | input | 1 | Consumer accepts the segment |
| segAddr | output | 31 | Segment address |
| segLen | output | 28 | Segment length in bytes |
| segLast | output | 1 | Segment carries the end marker |
| done | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Walk ended at the entry budget without a marker |
| doneCount | output | CNT_W | Descriptors consumed by the last walk |

## Verification
The bench builds the walker with MAX_ENTRIES set to 8 and keeps the 32-bit address width. This makes the budget cut-off, a marker landing exactly on the eighth entry, and lists that run past the budget all reachable with short descriptor tables. Random stall patterns on both the read port and the segment port hit back-pressure at every stage of the fetch. Descriptor words with all bits set show that the masked-off bits are dropped.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;
  localparam int WORD_W      = 32;
  localparam int SEG_LEN_W   = 28;
  localparam int SEG_ADDR_W  = 31;
  localparam int END_BIT     = 31;
  localparam int DESC_BYTES  = 8;
  localparam int HI_OFFSET   = 4;

  typedef struct packed {
    logic loadBase;
    logic reqHi;
    logic captureLen;
    logic captureAdr;
    logic advance;
    logic finish;
    logic finishErr;
  } walk_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ_LEN, ST_WAIT_LEN, ST_REQ_ADR, ST_WAIT_ADR, ST_EMIT
  } walk_state_t;
endpackage

// File: rtl/sg_walk_ctrl.sv
module sg_walk_ctrl
  import sg_walk_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         segReady,
  input  logic         endFlag,
  input  logic         atCap,
  output logic         busy,
  output logic         memReqValid,
  output logic         segValid,
  output walk_strobe_t stb
);
  walk_state_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb = '0;
    stb.reqHi = (state == ST_REQ_ADR);
    case (state)
      ST_IDLE: if (start) begin
        stb.loadBase = 1'b1;
        nextState = ST_REQ_LEN;
      end
      ST_REQ_LEN:  if (memReqReady) nextState = ST_WAIT_LEN;
      ST_WAIT_LEN: if (memRspValid) begin
        stb.captureLen = 1'b1;
        nextState = ST_REQ_ADR;
      end
      ST_REQ_ADR:  if (memReqReady) nextState = ST_WAIT_ADR;
      ST_WAIT_ADR: if (memRspValid) begin
        stb.captureAdr = 1'b1;
        nextState = ST_EMIT;
      end
      ST_EMIT: if (segReady) begin
        stb.advance = 1'b1;
        if (endFlag || atCap) begin
          stb.finish = 1'b1;
          stb.finishErr = !endFlag;
          nextState = ST_IDLE;
        end else begin
          nextState = ST_REQ_LEN;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_REQ_LEN) || (state == ST_REQ_ADR);
  assign segValid    = (state == ST_EMIT);
endmodule

// File: rtl/sg_walk_datapath.sv
module sg_walk_datapath
  import sg_walk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 16,
  parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  walk_strobe_t          stb,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [WORD_W-1:0]     memRspData,
  output logic [ADDR_W-1:0]     memReqAddr,
  output logic [SEG_ADDR_W-1:0] segAddr,
  output logic [SEG_LEN_W-1:0]  segLen,
  output logic                  segLast,
  output logic                  endFlag,
  output logic                  atCap,
  output logic                  done,
  output logic                  doneErr,
  output logic [CNT_W-1:0]      doneCount
);
  logic [ADDR_W-1:0]     baseReg;
  logic [CNT_W-1:0]      entryIdx;
  logic [SEG_LEN_W-1:0]  lenReg;
  logic                  endReg;
  logic [SEG_ADDR_W-1:0] adrReg;
  logic [CNT_W-1:0]      nextIdx;

  assign nextIdx = entryIdx + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseReg   <= '0;
      entryIdx  <= '0;
      lenReg    <= '0;
      endReg    <= 1'b0;
      adrReg    <= '0;
      done      <= 1'b0;
      doneErr   <= 1'b0;
      doneCount <= '0;
    end else begin
      done <= stb.finish;
      if (stb.loadBase) begin
        baseReg  <= baseAddr;
        entryIdx <= '0;
      end
      if (stb.captureLen) begin
        lenReg <= memRspData[SEG_LEN_W-1:0];
        endReg <= memRspData[END_BIT];
      end
      if (stb.captureAdr) adrReg <= memRspData[SEG_ADDR_W-1:0];
      if (stb.advance) entryIdx <= nextIdx;
      if (stb.finish) begin
        doneErr   <= stb.finishErr;
        doneCount <= nextIdx;
      end
    end
  end

  assign memReqAddr = baseReg + (ADDR_W'(entryIdx) * ADDR_W'(DESC_BYTES))
                    + (stb.reqHi ? ADDR_W'(HI_OFFSET) : '0);
  assign segAddr = adrReg;
  assign segLen  = lenReg;
  assign segLast = endReg;
  assign endFlag = endReg;
  assign atCap   = (entryIdx == CNT_W'(MAX_ENTRIES - 1));
endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker
  import sg_walk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 16,
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     baseAddr,
  output logic                  busy,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [ADDR_W-1:0]     memReqAddr,
  input  logic                  memRspValid,
  input  logic [31:0]           memRspData,
  output logic                  segValid,
  input  logic                  segReady,
  output logic [30:0]           segAddr,
  output logic [27:0]           segLen,
  output logic                  segLast,
  output logic                  done,
  output logic                  doneErr,
  output logic [CNT_W-1:0]      doneCount
);
  walk_strobe_t stb;
  logic endFlag, atCap;

  sg_walk_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .segReady(segReady), .endFlag(endFlag), .atCap(atCap),
    .busy(busy), .memReqValid(memReqValid), .segValid(segValid), .stb(stb)
  );

  sg_walk_datapath #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .baseAddr(baseAddr),
    .memRspData(memRspData), .memReqAddr(memReqAddr),
    .segAddr(segAddr), .segLen(segLen), .segLast(segLast),
    .endFlag(endFlag), .atCap(atCap),
    .done(done), .doneErr(doneErr), .doneCount(doneCount)
  );
endmodule

// File: rtl/sg_desc_walker_checker.sv
module sg_desc_walker_checker #(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 16,
  parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              segValid,
  input logic              segReady,
  input logic [30:0]       segAddr,
  input logic [27:0]       segLen,
  input logic              segLast,
  input logic              done,
  input logic              doneErr,
  input logic [CNT_W-1:0]  doneCount
);
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  assert_seg_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    segValid && !segReady |=> segValid && $stable(segAddr) && $stable(segLen) && $stable(segLast));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(segValid && memReqValid));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memReqValid && !segValid);

  assert_cap_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && doneErr |-> doneCount == CNT_W'(MAX_ENTRIES));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  assert_done_after_seg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(segValid && segReady));
endmodule

bind sg_desc_walker sg_desc_walker_checker #(
  .ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W)
) checker_i (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .segValid(segValid), .segReady(segReady), .segAddr(segAddr),
  .segLen(segLen), .segLast(segLast),
  .done(done), .doneErr(doneErr), .doneCount(doneCount)
);

// File: tb/sg_desc_walker_tb_top.sv
module sg_desc_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXE = 8;
  localparam int CW = $clog2(MAXE + 1);
  localparam int TAB = 12;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] baseAddr = 0;
  logic busy, memReqValid, memReqReady = 0, memRspValid = 0;
  logic [31:0] memReqAddr, memRspData = 0;
  logic segValid, segReady = 0, segLast, done, doneErr;
  logic [30:0] segAddr;
  logic [27:0] segLen;
  logic [CW-1:0] doneCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_desc_walker #(.ADDR_W(32), .MAX_ENTRIES(MAXE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .baseAddr(baseAddr), .busy(busy),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .segValid(segValid), .segReady(segReady), .segAddr(segAddr), .segLen(segLen),
    .segLast(segLast), .done(done), .doneErr(doneErr), .doneCount(doneCount)
  );

  int vecCount = 0, missCount = 0;
  logic [31:0] lenTab [TAB];
  logic [31:0] adrTab [TAB];
  logic [31:0] walkBase = 0;
  int expSegs = 0, expErrInt = 0;
  int segSeen = 0, reqIdx = 0, reqHi = 0;
  bit gotDone = 0, prevDone = 0, monEn = 0;
  bit pend = 0; int pendDelay = 0; logic [31:0] pendAddr = 0;
  int rdyPct = 70;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] off = a - walkBase;
    int i = int'(off >> 3);
    if (off[31:3] >= TAB) return 32'hA5A5_5A5A;
    return off[2] ? adrTab[i] : lenTab[i];
  endfunction

  function automatic void predict();
    expSegs = 0; expErrInt = 1;
    for (int i = 0; i < MAXE; i++) begin
      expSegs = i + 1;
      if (lenTab[i][31]) begin expErrInt = 0; break; end
    end
  endfunction

  always @(negedge clk) begin
    if (monEn) begin
      // memory response side
      memRspValid = 0;
      if (pend) begin
        if (pendDelay == 0) begin
          memRspValid = 1; memRspData = memWord(pendAddr); pend = 0;
        end else pendDelay--;
      end
      memReqReady = !pend && !memRspValid && ($urandom_range(99) < rdyPct);
      if (memReqValid && memReqReady) begin
        // R2: expected fetch order length word then address word
        chk(memReqAddr == walkBase + 32'(reqIdx * 8 + reqHi * 4), "R2", "request address",
            memReqAddr, walkBase + 32'(reqIdx * 8 + reqHi * 4));
        if (reqHi == 1) begin reqHi = 0; reqIdx++; end else reqHi = 1;
        pend = 1; pendAddr = memReqAddr; pendDelay = $urandom_range(2);
      end
      segReady = ($urandom_range(99) < rdyPct);
      if (segValid && segReady) begin
        // R3 R4: masked fields of descriptor segSeen
        chk(segSeen < expSegs, "R6", "segment beyond end", segSeen, expSegs);
        if (segSeen < TAB) begin
          chk(segLen == lenTab[segSeen][27:0], "R3", "segLen", segLen, lenTab[segSeen][27:0]);
          chk(segLast == lenTab[segSeen][31], "R3", "segLast", segLast, lenTab[segSeen][31]);
          chk(segAddr == adrTab[segSeen][30:0], "R4", "segAddr", segAddr, adrTab[segSeen][30:0]);
        end
        chk(!pend && !memRspValid, "R5", "read outstanding at emit", pend, 0);
        segSeen++;
      end
      if (prevDone) chk(!done, "R9", "done longer than one cycle", done, 0);
      if (done) begin
        chk(!busy, "R9", "busy during done", busy, 0);
        chk(doneErr == expErrInt[0], expErrInt ? "R7" : "R6", "doneErr", doneErr, expErrInt);
        chk(int'(doneCount) == expSegs, expErrInt ? "R7" : "R6", "doneCount", doneCount, expSegs);
        chk(segSeen == expSegs, "R6", "segments emitted", segSeen, expSegs);
        gotDone = 1;
      end
      prevDone = done;
    end
  end

  task automatic runWalk(input logic [31:0] b, input bit poke);
    int guard = 0;
    predict();
    @(negedge clk);
    walkBase = b; segSeen = 0; reqIdx = 0; reqHi = 0; gotDone = 0;
    baseAddr = b; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (6) @(negedge clk);
      // R8: a second start with another base while busy
      chk(busy, "R8", "busy before poke", busy, 1);
      baseAddr = b + 32'h100; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!gotDone && guard < 3000) begin @(negedge clk); guard++; end
    if (!gotDone) chk(0, "R6", "walk watchdog", guard, 0);
    @(negedge clk);
    chk(!done && doneErr == expErrInt[0], "R9", "done held status", doneErr, expErrInt);
  endtask

  task automatic fill(input int lastAt, input bit ones);
    for (int i = 0; i < TAB; i++) begin
      lenTab[i] = ones ? 32'h7FFF_FFFF : {1'b0, 3'($urandom), 28'($urandom)};
      adrTab[i] = ones ? 32'hFFFF_FFFF : $urandom;
      if (i == lastAt) lenTab[i][31] = 1'b1;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !memReqValid && !segValid && !done && !doneErr && doneCount == 0,
        "R1", "reset outputs", {busy, memReqValid, segValid, done, doneErr}, 0);
    rst_n = 1;
    monEn = 1;
    fill(0, 0);  runWalk(32'h0000_1000, 0);            // single entry
    fill(7, 0);  runWalk(32'h0000_2000, 0);            // R7: marker on entry MAXE
    fill(-1, 0); runWalk(32'h0000_3000, 0);            // R7: no marker, cap hit
    fill(2, 1);  lenTab[2] = 32'hFFFF_FFFF; runWalk(32'h0040_0008, 0); // R3 R4 masking
    fill(4, 0);  runWalk(32'h0000_5000, 1);            // R8: start while busy
    rdyPct = 100; fill(3, 0); runWalk(32'hFFFF_FFF0, 0); // address wrap, no stalls
    for (int t = 0; t < 40; t++) begin
      rdyPct = 20 + int'($urandom_range(80));
      fill(int'($urandom_range(10)) - 1, 0);
      runWalk($urandom & 32'hFFFF_FFF8, t % 7 == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    missCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule